// File: doc/BRIEF.md
# Nested-Route Range Update Engine

This engine rewrites the next hop of one route in an expanded first-level forwarding table. A route of prefix length `len` covers 2^(IDX_W-len) consecutive table entries. Some of those entries may belong to longer routes nested inside it. The engine receives one command that holds the first entry, the prefix length and the new next hop. It then walks the covered entries in ascending order. It replaces the next hop only where the entry belongs to the commanded route, and it leaves the holes owned by nested routes exactly as they were.

Each entry stores a 2-bit marker that records where routes begin and end. Routes are either disjoint or fully nested, so the markers pair up like brackets. The engine keeps a running depth count while it walks, and it needs no prefix-length field in the entry. Every entry costs one read and, when the entry is owned by the commanded route, one write that keeps the marker bits.

The table memory is outside the engine and is shared with the lookup path, which has priority. While `lkp_busy` is high the engine issues no access and holds its place in the scan. The command port uses a valid/ready handshake: a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The caller must hold `cmd_valid` and the command fields steady until that cycle. `cmd_ready` stays low for the whole update, so a held command simply waits.

Top module: `nest_upd_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle; a command is taken when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` stays low from that cycle until after `done`.
- R2: A command with start S and length L reads exactly 2^(IDX_W-L) entries, addressed S, S+1, ... in ascending order; L = 0 walks the whole table and L >= IDX_W reads only entry S.
- R3: An entry is `{marker[1:0], hop[HOP_W-1:0]}` with the marker in the top two bits, coded 00 = inside a route, 01 = route opens here, 10 = route closes here, 11 = one-entry route (opens and closes).
- R4: Every write goes to the address read just before it, keeps the marker bits that were read, and carries the commanded next hop in the low HOP_W bits.
- R5: The first entry of the walk is always written. On a later entry, an open bit raises the relative depth before the entry is tested and a close bit lowers it after the test. The entry is written if and only if the tested depth is 0.
- R6: Entries that belong to a route nested inside the commanded one are never written, including the entries that carry that route's markers.
- R7: A one-entry nested route (marker 11) is skipped and leaves the depth for the following entries unchanged.
- R8: No memory request is issued in a cycle where `lkp_busy` is high. A stalled scan resumes at the same entry and skips or repeats none.
- R9: `done` is high for exactly one cycle after the last entry has been handled, and `cmd_ready` is high in the cycle that follows.
- R10: After reset `cmd_ready` is high and `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Update command offered |
| cmd_ready | output | 1 | Engine idle, can take a command |
| cmd_start | input | IDX_W | First table entry of the route |
| cmd_len | input | LEN_W | Prefix length of the route, 0 to IDX_W |
| cmd_hop | input | HOP_W | New next hop |
| lkp_busy | input | 1 | Lookup path owns the memory this cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write when mem_req is high |
| mem_addr | output | IDX_W | Entry address |
| mem_wdata | output | HOP_W+2 | Entry to write |
| mem_rdata | input | HOP_W+2 | Entry read, valid the cycle after a read |
| done | output | 1 | One-cycle pulse when the update is finished |

## Verification
The table is filled with a nest of routes: one covering the whole table, a mid-level route holding a deeper route, single-entry routes at two depths, and disjoint siblings. Updating the outermost route tests whether holes at several depths are skipped and whether depth returns to zero after each nested close. Updating a mid-level route and then the innermost ones tests the first-entry rule and single-entry walks. Pattern-driven `lkp_busy` stalls on some commands show whether a scan keeps its place when accesses are refused.

// File: rtl/nest_upd_pkg.sv
package nest_upd_pkg;

  // 2-bit nesting marker held in the top bits of each entry
  typedef enum logic [1:0] {
    MK_MID   = 2'b00,
    MK_OPEN  = 2'b01,
    MK_CLOSE = 2'b10,
    MK_BOTH  = 2'b11
  } mark_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_DONE
  } eng_state_e;

  function automatic logic mk_opens(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mk_closes(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/scan_walker.sv
module scan_walker #(
  parameter int IDX_W = 24,
  parameter int LEN_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] start,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic [IDX_W-1:0] addr,
  output logic             first,
  output logic             last
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(IDX_W);

  logic [LEN_W-1:0] sh_amt;
  logic [IDX_W:0]   span;
  logic [IDX_W-1:0] rem_q;
  logic [IDX_W-1:0] addr_q;
  logic             first_q;

  always_comb begin
    sh_amt = (len >= FULL_LEN) ? '0 : (FULL_LEN - len);
    span   = {{IDX_W{1'b0}}, 1'b1} << sh_amt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      addr_q  <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      rem_q   <= IDX_W'(span - 1'b1);
      addr_q  <= start;
      first_q <= 1'b1;
    end else if (step) begin
      rem_q   <= rem_q - 1'b1;
      addr_q  <= addr_q + 1'b1;
      first_q <= 1'b0;
    end
  end

  assign addr  = addr_q;
  assign first = first_q;
  assign last  = (rem_q == '0);

endmodule

// File: rtl/depth_tracker.sv
module depth_tracker #(
  parameter int IDX_W = 24,
  parameter int DEP_W = $clog2(IDX_W + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic       first,
  input  logic [1:0] mark,
  output logic       hit
);
  import nest_upd_pkg::*;

  logic [DEP_W-1:0] depth_q;
  logic [DEP_W-1:0] raised;
  logic [DEP_W-1:0] depth_d;

  always_comb begin
    raised = depth_q + DEP_W'(mk_opens(mark));
    hit    = first || (raised == '0);
    if (first)
      depth_d = '0;
    else if (mk_closes(mark) && (raised != '0))
      depth_d = raised - 1'b1;
    else
      depth_d = raised;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      depth_q <= '0;
    else if (step)
      depth_q <= depth_d;
  end

endmodule

// File: rtl/nest_upd_engine.sv
module nest_upd_engine #(
  parameter int IDX_W = 24,
  parameter int HOP_W = 15,
  parameter int LEN_W = $clog2(IDX_W + 1),
  parameter int ENT_W = HOP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] cmd_start,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [HOP_W-1:0] cmd_hop,
  input  logic             lkp_busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             done
);
  import nest_upd_pkg::*;

  localparam logic [ENT_W-1:0] MARK_MASK = {2'b11, {HOP_W{1'b0}}};

  eng_state_e       state_q;
  logic [HOP_W-1:0] hop_q;
  logic [ENT_W-1:0] ent_q;
  logic             hit_q;
  logic             accept;
  logic             advance;
  logic [IDX_W-1:0] cur_addr;
  logic             cur_first;
  logic             cur_last;
  logic             dep_hit;

  assign accept  = cmd_valid && cmd_ready;
  assign advance = (state_q == ST_WRITE) && (!hit_q || !lkp_busy);

  scan_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .start (cmd_start),
    .len   (cmd_len),
    .step  (advance && !cur_last),
    .addr  (cur_addr),
    .first (cur_first),
    .last  (cur_last)
  );

  depth_tracker #(.IDX_W(IDX_W)) u_depth (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (state_q == ST_EVAL),
    .first (cur_first),
    .mark  (mem_rdata[ENT_W-1 -: 2]),
    .hit   (dep_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hop_q   <= '0;
      ent_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          hop_q   <= cmd_hop;
          state_q <= ST_READ;
        end
        ST_READ: if (!lkp_busy) state_q <= ST_EVAL;
        ST_EVAL: begin
          ent_q   <= mem_rdata;
          hit_q   <= dep_hit;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (advance) state_q <= cur_last ? ST_DONE : ST_READ;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    done      = (state_q == ST_DONE);
    mem_we    = (state_q == ST_WRITE);
    mem_addr  = cur_addr;
    mem_wdata = (ent_q & MARK_MASK) | {2'b00, hop_q};
    unique case (state_q)
      ST_READ:  mem_req = !lkp_busy;
      ST_WRITE: mem_req = hit_q && !lkp_busy;
      default:  mem_req = 1'b0;
    endcase
  end

endmodule

// File: rtl/nest_upd_engine_chk.sv
module nest_upd_engine_chk #(
  parameter int IDX_W = 24,
  parameter int HOP_W = 15,
  parameter int ENT_W = HOP_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             lkp_busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic [ENT_W-1:0] mem_wdata,
  input logic [ENT_W-1:0] mem_rdata,
  input logic             done
);

  logic             rd_pend;
  logic             have_rd;
  logic [IDX_W-1:0] rd_addr;
  logic [1:0]       rd_mark;
  logic             seq_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      have_rd <= 1'b0;
      rd_addr <= '0;
      rd_mark <= '0;
      seq_v   <= 1'b0;
    end else begin
      rd_pend <= mem_req && !mem_we;
      if (mem_req && !mem_we) rd_addr <= mem_addr;
      if (rd_pend) begin
        rd_mark <= mem_rdata[ENT_W-1 -: 2];
        have_rd <= 1'b1;
      end else if (mem_req && mem_we) begin
        have_rd <= 1'b0;
      end
      if (cmd_valid && cmd_ready) seq_v <= 1'b0;
      else if (mem_req && !mem_we) seq_v <= 1'b1;
    end
  end

  AST_YIELD_TO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !lkp_busy); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R1

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && seq_v) |-> (mem_addr == IDX_W'(rd_addr + 1'b1))); // R2

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (have_rd && mem_addr == rd_addr
                             && mem_wdata[ENT_W-1 -: 2] == rd_mark)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R9

endmodule

bind nest_upd_engine nest_upd_engine_chk #(.IDX_W(IDX_W), .HOP_W(HOP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .lkp_busy  (lkp_busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .done      (done)
);

// File: tb/nest_upd_engine_test.sv
`timescale 1ns/1ps
module nest_upd_engine_test;

  localparam int IDX_W = 8;
  localparam int HOP_W = 6;
  localparam int LEN_W = 4;
  localparam int ENT_W = 8;
  localparam int DEPTH = 256;
  localparam int NR    = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [IDX_W-1:0] cmd_start = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [HOP_W-1:0] cmd_hop = '0;
  logic             lkp_busy = 1'b0;
  logic             mem_req;
  logic             mem_we;
  logic [IDX_W-1:0] mem_addr;
  logic [ENT_W-1:0] mem_wdata;
  logic [ENT_W-1:0] mem_rdata;
  logic             done;

  always #4 clk = ~clk;

  nest_upd_engine #(.IDX_W(IDX_W), .HOP_W(HOP_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_len(cmd_len), .cmd_hop(cmd_hop),
    .lkp_busy(lkp_busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done)
  );

  // table memory model: one process owns it
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] img [DEPTH];
  logic             init_req = 1'b0;

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // route set: start, length, current hop
  int r_start [NR] = '{0, 64, 80, 100, 132, 90, 160};
  int r_len   [NR] = '{0, 2, 4, 8, 6, 8, 5};
  int r_hop   [NR] = '{1, 2, 3, 4, 5, 6, 7};

  function automatic int r_span(input int k);
    return 1 << (IDX_W - r_len[k]);
  endfunction

  function automatic int owner(input int e);
    int best = -1;
    for (int k = 0; k < NR; k++)
      if (e >= r_start[k] && e < r_start[k] + r_span(k))
        if (best < 0 || r_len[k] > r_len[best]) best = k;
    return best;
  endfunction

  function automatic logic [1:0] marker(input int e);
    logic o = 1'b0;
    logic c = 1'b0;
    for (int k = 0; k < NR; k++) begin
      if (e == r_start[k]) o = 1'b1;
      if (e == r_start[k] + r_span(k) - 1) c = 1'b1;
    end
    return {c, o};
  endfunction

  // scoreboard of expected writes {addr, data}
  logic [15:0] sb_q [$];
  int  rd_exp = 0;
  int  rd_cnt = 0;
  bit  stall_on = 1'b0;
  int  cyc = 0;

  always begin
    @(posedge clk);
    #1;
    cyc++;
    lkp_busy = stall_on && ((cyc % 3 == 0) || (cyc % 5 == 1));
  end

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      chk(!lkp_busy, "R8 request while lookup busy", 1, 0);
      if (!mem_we) begin
        chk(int'(mem_addr) == rd_exp, "R2 read address", mem_addr, rd_exp);
        rd_exp++;
        rd_cnt++;
      end else if (sb_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write", mem_addr, -1);
      end else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        chk(mem_addr == e[15:8], "R5 write address", mem_addr, e[15:8]);
        chk(mem_wdata == e[7:0], "R4 write data", mem_wdata, e[7:0]);
      end
    end
  end

  task automatic build_table();
    for (int e = 0; e < DEPTH; e++)
      img[e] = {marker(e), HOP_W'(r_hop[owner(e)])};
    @(negedge clk);
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic run_cmd(input int k, input int hop, input bit stall, input string tag);
    int mism;
    for (int e = r_start[k]; e < r_start[k] + r_span(k); e++) begin
      if (owner(e) == k) begin
        img[e] = {img[e][7:6], HOP_W'(hop)};
        sb_q.push_back({8'(e), img[e]});
      end
    end
    r_hop[k] = hop;
    rd_exp = r_start[k];
    rd_cnt = 0;
    stall_on = stall;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_start = IDX_W'(r_start[k]);
    cmd_len   = LEN_W'(r_len[k]);
    cmd_hop   = HOP_W'(hop);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 ready low after accept", cmd_ready, 0);
    while (!done) @(negedge clk);
    chk(sb_q.size() == 0, "R5 writes outstanding at done", sb_q.size(), 0);
    chk(rd_cnt == r_span(k), "R2 entries read", rd_cnt, r_span(k));
    @(negedge clk);
    chk(!done && cmd_ready, "R9 done pulse then ready", {done, cmd_ready}, 1);
    stall_on = 1'b0;
    mism = 0;
    for (int e = 0; e < DEPTH; e++) if (mem[e] !== img[e]) mism++;
    chk(mism == 0, tag, mism, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !mem_req && !done, "R10 reset state",
        {cmd_ready, mem_req, done}, 4);
    rst_n = 1'b1;
    build_table();
    // R3 markers: 01 open, 10 close, 11 single, 00 inside
    run_cmd(0, 11, 1'b0, "R6 outer route leaves nested holes");
    run_cmd(1, 22, 1'b1, "R7 mid route skips one-entry hole under stall");
    run_cmd(2, 33, 1'b0, "R6 deeper route skips inner single entry");
    run_cmd(3, 44, 1'b0, "R5 one-entry route written alone");
    run_cmd(5, 45, 1'b1, "R3 innermost single entry keeps marker 11");
    run_cmd(4, 50, 1'b0, "R2 short sibling route");
    run_cmd(0, 55, 1'b1, "R8 outer route again with stalls");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule